// File: doc/BRIEF.md
# Selector-Extended ALU with Condition Flags

This block is the execute stage and operation decoder of a 16-bit processor. It adds six logic and arithmetic operations without spending any new opcode. In the register-register form of the add and bitwise-and instructions, two bits that were unused until now become a function selector. Each of the two opcodes then carries four operations, and selector 00 keeps the original one. The immediate forms of both instructions behave as they did before.

The block takes an instruction word, an issue strobe and two 16-bit source operands. One clock later it returns the result, a register-write strobe and the three condition flags, which record whether the result is negative, zero or positive. The flags are held in a register inside the block. They change only when an add-group or and-group instruction is issued.

Top module: `alu_fs_top`

## Requirements
- R1: After reset, `result_o` is 0, `reg_wr_o` is 0 and `nzp_o` is 3'b010 (the zero flag alone is set).
- R2: When an instruction with opcode bits [15:12] = 4'b0001 and bit 5 = 0 is issued, the result one cycle later depends on selector bits [4:3]: 00 gives A+B, 01 gives A−B, 10 gives A XOR B and 11 gives A XNOR B.
- R3: Subtraction wraps modulo 2^16, so A−B equals A + (~B) + 1 truncated to 16 bits, including when B is 0 and when B is 16'h8000.
- R4: When an instruction with opcode bits [15:12] = 4'b0101 and bit 5 = 0 is issued, the result depends on bits [4:3]: 00 gives A AND B, 01 gives A OR B, 10 gives NOT(A AND B) and 11 gives NOT(A OR B).
- R5: When bit 5 = 1, the selector bits are ignored. The second operand is bits [4:0] sign-extended to 16 bits, and the operation is ADD for opcode 0001 and AND for opcode 0101.
- R6: `nzp_o` is {N,Z,P}, with N in bit 2. After each add-group or and-group result it holds N for a result with bit 15 set, Z for a result of zero and P for any other result. Exactly one flag is set at all times.
- R7: `reg_wr_o` is 1 only in the cycle that follows an issued add-group or and-group instruction.
- R8: A cycle with `issue_i` low, or an issued instruction with any other opcode, leaves `result_o` and `nzp_o` unchanged and keeps `reg_wr_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| src_a_i | input | 16 | First source operand |
| src_b_i | input | 16 | Second source operand (register form) |
| result_o | output | 16 | Registered operation result |
| reg_wr_o | output | 1 | Destination register write strobe |
| nzp_o | output | 3 | Condition flags {N,Z,P} |

## Verification
The assertions are checked on every clock cycle. They cover the following:
- the flags stay one-hot;
- the flags agree with the registered result whenever a write is signalled;
- the flags do not move between updates;
- the write strobe appears only after an issued add-group or and-group instruction;
- the result of a subtraction equals the two's-complement difference of the operands that were issued.

Only the bench's scenarios can show the following:
- every selector code under both opcodes gives the right operation;
- the immediate forms ignore bits [4:3] and sign-extend their constant;
- the result and flags are held across idle cycles and across instructions from other opcodes.

// File: rtl/alu_fs_pkg.sv
package alu_fs_pkg;
  localparam logic [3:0] OPC_ADDGRP = 4'b0001;
  localparam logic [3:0] OPC_ANDGRP = 4'b0101;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_XOR  = 3'd2,
    OP_XNOR = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_NAND = 3'd6,
    OP_NOR  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_fs_decode.sv
module alu_fs_decode
  import alu_fs_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 5
) (
  input  logic [15:0]      instr,
  output logic             is_alu,
  output logic             use_imm,
  output alu_op_e          op,
  output logic [WIDTH-1:0] imm_ext
);
  localparam int EXT_W = WIDTH - IMM_W;

  logic [3:0] opcode;
  logic [1:0] fsel;

  always_comb begin
    opcode  = instr[15:12];
    fsel    = instr[4:3];
    use_imm = instr[5];
    imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    is_alu  = 1'b0;
    op      = OP_ADD;
    if (opcode == OPC_ADDGRP) begin
      is_alu = 1'b1;
      if (use_imm) op = OP_ADD;
      else begin
        case (fsel)
          2'b00:   op = OP_ADD;
          2'b01:   op = OP_SUB;
          2'b10:   op = OP_XOR;
          default: op = OP_XNOR;
        endcase
      end
    end else if (opcode == OPC_ANDGRP) begin
      is_alu = 1'b1;
      if (use_imm) op = OP_AND;
      else begin
        case (fsel)
          2'b00:   op = OP_AND;
          2'b01:   op = OP_OR;
          2'b10:   op = OP_NAND;
          default: op = OP_NOR;
        endcase
      end
    end
  end
endmodule

// File: rtl/alu_fs_exec.sv
module alu_fs_exec
  import alu_fs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res
);
  logic             sub_sel;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;

  // one adder serves both add and subtract: A + ~B + 1
  always_comb begin
    sub_sel = (op == OP_SUB);
    addend  = sub_sel ? ~opb : opb;
    sum     = opa + addend + {{(WIDTH-1){1'b0}}, sub_sel};
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: res = sum;
      OP_XOR:         res = opa ^ opb;
      OP_XNOR:        res = ~(opa ^ opb);
      OP_AND:         res = opa & opb;
      OP_OR:          res = opa | opb;
      OP_NAND:        res = ~(opa & opb);
      default:        res = ~(opa | opb);
    endcase
  end
endmodule

// File: rtl/alu_fs_flags.sv
module alu_fs_flags #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] value,
  output logic [2:0]       nzp
);
  logic [2:0] nzp_d;
  logic [2:0] nzp_q;

  always_comb begin
    nzp_d = nzp_q;
    if (upd_en) begin
      if (value[WIDTH-1])   nzp_d = 3'b100;
      else if (value == '0) nzp_d = 3'b010;
      else                  nzp_d = 3'b001;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nzp_q <= 3'b010;
    else        nzp_q <= nzp_d;
  end

  assign nzp = nzp_q;

  AST_NZP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nzp_q) == 1); // R6
  AST_NZP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(nzp_q)); // R8
endmodule

// File: rtl/alu_fs_top.sv
module alu_fs_top
  import alu_fs_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [15:0]      instr_i,
  input  logic [WIDTH-1:0] src_a_i,
  input  logic [WIDTH-1:0] src_b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             reg_wr_o,
  output logic [2:0]       nzp_o
);
  logic             dec_is_alu;
  logic             dec_use_imm;
  alu_op_e          dec_op;
  logic [WIDTH-1:0] dec_imm;
  logic [WIDTH-1:0] opb;
  logic [WIDTH-1:0] exe_res;
  logic             fire;
  logic [WIDTH-1:0] res_d;
  logic [WIDTH-1:0] res_q;
  logic             wr_q;

  alu_fs_decode #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dec (
    .instr   (instr_i),
    .is_alu  (dec_is_alu),
    .use_imm (dec_use_imm),
    .op      (dec_op),
    .imm_ext (dec_imm)
  );

  assign opb = dec_use_imm ? dec_imm : src_b_i;

  alu_fs_exec #(.WIDTH(WIDTH)) u_exe (
    .op  (dec_op),
    .opa (src_a_i),
    .opb (opb),
    .res (exe_res)
  );

  always_comb begin
    fire  = issue_i && dec_is_alu;
    res_d = fire ? exe_res : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      wr_q  <= fire;
    end
  end

  alu_fs_flags #(.WIDTH(WIDTH)) u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (fire),
    .value  (exe_res),
    .nzp    (nzp_o)
  );

  assign result_o = res_q;
  assign reg_wr_o = wr_q;

  AST_WR_AFTER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_i && dec_is_alu) |=> !reg_wr_o); // R7
  AST_N_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (nzp_o[2] == result_o[WIDTH-1])); // R6
  AST_Z_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (nzp_o[1] == (result_o == '0))); // R6
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && dec_is_alu && dec_op == OP_SUB) |=>
      (result_o == $past(src_a_i - src_b_i))); // R3
endmodule

// File: tb/alu_fs_top_tb.sv
module alu_fs_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [15:0] instr_i;
  logic [15:0] src_a_i;
  logic [15:0] src_b_i;
  logic [15:0] result_o;
  logic        reg_wr_o;
  logic [2:0]  nzp_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  alu_fs_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .instr_i  (instr_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .reg_wr_o (reg_wr_o),
    .nzp_o    (nzp_o)
  );

  function automatic logic [15:0] model_res(input logic [15:0] ins,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
    logic [15:0] bb;
    bb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
    if (ins[15:12] == 4'b0001) begin
      if (ins[5]) return a + bb;
      case (ins[4:3])
        2'b00:   return a + bb;
        2'b01:   return a - bb;
        2'b10:   return a ^ bb;
        default: return ~(a ^ bb);
      endcase
    end else begin
      if (ins[5]) return a & bb;
      case (ins[4:3])
        2'b00:   return a & bb;
        2'b01:   return a | bb;
        2'b10:   return ~(a & bb);
        default: return ~(a | bb);
      endcase
    end
  endfunction

  function automatic logic [2:0] model_nzp(input logic [15:0] r);
    if (r[15])       return 3'b100;
    else if (r == 0) return 3'b010;
    else             return 3'b001;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture on posedge, sample at following negedge
  task automatic run_op(input string req, input logic [15:0] ins,
                        input logic [15:0] a, input logic [15:0] b);
    logic [15:0] er;
    er = model_res(ins, a, b);
    issue_i = 1'b1; instr_i = ins; src_a_i = a; src_b_i = b;
    @(negedge clk);
    issue_i = 1'b0;
    check(req, {16'd0, result_o}, {16'd0, er});
    check("R6", {29'd0, nzp_o}, {29'd0, model_nzp(er)});
    check("R7", {31'd0, reg_wr_o}, 32'd1);
  endtask

  task automatic run_hold(input string req, input logic iss,
                          input logic [15:0] ins);
    logic [15:0] r0;
    logic [2:0]  f0;
    r0 = result_o; f0 = nzp_o;
    issue_i = iss; instr_i = ins;
    src_a_i = 16'h1234; src_b_i = 16'h8001;
    @(negedge clk);
    issue_i = 1'b0;
    check(req, {16'd0, result_o}, {16'd0, r0});
    check(req, {29'd0, nzp_o}, {29'd0, f0});
    check("R7", {31'd0, reg_wr_o}, 32'd0);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] opc, input logic imm,
                                     input logic [4:0] low);
    return {opc, 3'd1, 3'd2, imm, low};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_0411;
    void'($urandom(seed));
    rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; src_a_i = '0; src_b_i = '0;
    repeat (3) @(negedge clk);
    check("R1", {16'd0, result_o}, 32'd0);
    check("R1", {31'd0, reg_wr_o}, 32'd0);
    check("R1", {29'd0, nzp_o}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: each selector under both opcodes
    run_op("R2", mk(4'b0001, 1'b0, 5'b00_000), 16'h0003, 16'h0004);
    run_op("R2", mk(4'b0001, 1'b0, 5'b01_000), 16'h0003, 16'h0004);
    run_op("R2", mk(4'b0001, 1'b0, 5'b10_000), 16'hF0F0, 16'hFF00);
    run_op("R2", mk(4'b0001, 1'b0, 5'b11_000), 16'hF0F0, 16'hFF00);
    run_op("R4", mk(4'b0101, 1'b0, 5'b00_000), 16'hF0F0, 16'hFF00);
    run_op("R4", mk(4'b0101, 1'b0, 5'b01_000), 16'hF0F0, 16'hFF00);
    run_op("R4", mk(4'b0101, 1'b0, 5'b10_000), 16'hF0F0, 16'hFF00);
    run_op("R4", mk(4'b0101, 1'b0, 5'b11_000), 16'hF0F0, 16'h0F00);
    // subtract corners
    run_op("R3", mk(4'b0001, 1'b0, 5'b01_000), 16'h1234, 16'h0000);
    run_op("R3", mk(4'b0001, 1'b0, 5'b01_000), 16'h0000, 16'h8000);
    run_op("R3", mk(4'b0001, 1'b0, 5'b01_000), 16'h5555, 16'h5555);
    run_op("R3", mk(4'b0001, 1'b0, 5'b01_000), 16'h0000, 16'h0001);
    // immediate forms with selector bits set, negative and positive constants
    run_op("R5", mk(4'b0001, 1'b1, 5'b11_111), 16'h0001, 16'h7777);
    run_op("R5", mk(4'b0001, 1'b1, 5'b01_010), 16'h0010, 16'h7777);
    run_op("R5", mk(4'b0101, 1'b1, 5'b10_110), 16'hABCD, 16'h0000);
    run_op("R5", mk(4'b0101, 1'b1, 5'b11_001), 16'hABCD, 16'hFFFF);
    // hold cases
    run_hold("R8", 1'b0, mk(4'b0001, 1'b0, 5'b01_000));
    run_hold("R8", 1'b1, mk(4'b0000, 1'b0, 5'b00_000));
    run_hold("R8", 1'b1, mk(4'b1001, 1'b1, 5'b11_111));

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ins;
      logic [15:0] a;
      logic [15:0] b;
      ins = 16'($urandom);
      ins[15:12] = ($urandom % 2 == 0) ? 4'b0001 : 4'b0101;
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom % 8 == 0) b = a;
      run_op(ins[5] ? "R5" : (ins[15:12] == 4'b0001 ? "R2" : "R4"), ins, a, b);
      if ($urandom % 10 == 0) run_hold("R8", 1'b1, {4'b1100, 12'($urandom)});
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule